// File: doc/BRIEF.md
# Byte-Staged 16-bit Counter Access Port

This block sits between an 8-bit register bus and a free-running 16-bit counter. Software works on the counter one byte at a time. The block makes sure that a 16-bit value is always read and written as one unit.

A single low-byte holding buffer does all of the staging. On a write, the low byte is parked in the buffer. The following high-byte write then sends both halves to the counter together, as a one-cycle load pulse. On a read, a high-byte read returns the live high half. In the same cycle it freezes the live low half into the buffer. A later low-byte read returns that frozen copy, so the two bytes belong to the same counter value. Software must therefore write low then high, and read high then low.

The counter itself, and the priority of its load over its increment, are outside this block. The counter value arrives as an input, and the load leaves as a value plus a strobe.

Top module: `counter_byte_access`

## Requirements
- R1: After reset, `loadStrobe` is 0, `loadValue` is 0 and the holding buffer is 0, so a low-byte read with no earlier access returns 0.
- R2: A write with `addrHigh`=0 stores `wrData` only in the holding buffer. It raises no load pulse.
- R3: A write with `addrHigh`=1 raises `loadStrobe` in the next cycle. In that cycle `loadValue[15:8]` is the written byte and `loadValue[7:0]` is the buffer content before the write.
- R4: `loadStrobe` is high for exactly one cycle per high-byte write. It is low in any cycle that does not follow a high-byte write.
- R5: A read with `addrHigh`=1 returns `cntValue[15:8]` on `rdData` in the same cycle.
- R6: A read with `addrHigh`=1 and no write copies `cntValue[7:0]` into the buffer. A later low-byte read returns that copy and not the live low half.
- R7: A high-byte read overwrites a low byte that a write staged earlier but that no high-byte write has yet committed.
- R8: While `rdEn` is 0, `rdData` is 0.
- R9: When `wrEn` and `rdEn` are both high, the write acts on the buffer or the load. A simultaneous high-byte read then takes no snapshot, but it still returns the live high half.
- R10: A low-byte read leaves the buffer unchanged, so repeated low-byte reads return the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addrHigh | input | 1 | Byte select: 1 high byte, 0 low byte |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte (combinational) |
| cntValue | input | 16 | Live counter value |
| loadValue | output | 16 | Value to load into the counter |
| loadStrobe | output | 1 | One-cycle load request |

## Verification
Read data is combinational, so `rdData` is due in the same cycle as the read strobe. The bench checks it a quarter period after the inputs change, before the next rising edge. The load strobe and value come from a register, so they are due one cycle after the high-byte write. The bench checks them just after that rising edge. Buffer effects are seen one cycle later still, through the next low-byte read or the next high-byte write's `loadValue[7:0]`. The bench's model updates its buffer at the edge, so each check compares against the state that edge produced.

// File: rtl/byte_access_pkg.sv
package byte_access_pkg;
  typedef struct packed {
    logic stageLow;    // park write byte in buffer
    logic commitHigh;  // issue 16-bit load
    logic captureLow;  // snapshot live low half
    logic selHigh;     // drive live high half on read
    logic readEn;      // read data valid
  } accessStrobes_t;
endpackage

// File: rtl/byte_access_ctrl.sv
module byte_access_ctrl
  import byte_access_pkg::*;
(
  input  logic           addrHigh,
  input  logic           wrEn,
  input  logic           rdEn,
  output accessStrobes_t strobes
);
  always_comb begin
    strobes            = '0;
    strobes.stageLow   = wrEn && !addrHigh;
    strobes.commitHigh = wrEn && addrHigh;
    // a write in the same cycle wins over the snapshot
    strobes.captureLow = rdEn && addrHigh && !wrEn;
    strobes.selHigh    = rdEn && addrHigh;
    strobes.readEn     = rdEn;
  end
endmodule

// File: rtl/byte_access_datapath.sv
module byte_access_datapath
  import byte_access_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  accessStrobes_t    strobes,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cntValue,
  output logic [BYTE_W-1:0] rdData,
  output logic [CNT_W-1:0]  loadValue,
  output logic              loadStrobe
);
  logic [BYTE_W-1:0] lowBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowBuf <= '0;
    end else if (strobes.stageLow) begin
      lowBuf <= wrData;
    end else if (strobes.captureLow) begin
      lowBuf <= cntValue[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadStrobe <= 1'b0;
      loadValue  <= '0;
    end else begin
      loadStrobe <= strobes.commitHigh;
      if (strobes.commitHigh) begin
        loadValue <= {wrData, lowBuf};
      end
    end
  end

  always_comb begin
    if (!strobes.readEn) begin
      rdData = '0;
    end else if (strobes.selHigh) begin
      rdData = cntValue[CNT_W-1:BYTE_W];
    end else begin
      rdData = lowBuf;
    end
  end
endmodule

// File: rtl/counter_byte_access.sv
module counter_byte_access
  import byte_access_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrHigh,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic [CNT_W-1:0]  cntValue,
  output logic [CNT_W-1:0]  loadValue,
  output logic              loadStrobe
);
  accessStrobes_t strobes;

  byte_access_ctrl u_ctrl (
    .addrHigh (addrHigh),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .strobes  (strobes)
  );

  byte_access_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .cntValue   (cntValue),
    .rdData     (rdData),
    .loadValue  (loadValue),
    .loadStrobe (loadStrobe)
  );
endmodule

// File: rtl/counter_byte_access_checker.sv
module counter_byte_access_checker #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrHigh,
  input logic              wrEn,
  input logic              rdEn,
  input logic [BYTE_W-1:0] wrData,
  input logic [BYTE_W-1:0] rdData,
  input logic [CNT_W-1:0]  cntValue,
  input logic [CNT_W-1:0]  loadValue,
  input logic              loadStrobe
);
  assert_load_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrHigh) |=> (loadStrobe && loadValue[CNT_W-1:BYTE_W] == $past(wrData)));

  assert_load_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addrHigh) |=> !loadStrobe);

  assert_stage_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addrHigh) ##1 (wrEn && addrHigh) |=> loadValue[BYTE_W-1:0] == $past(wrData, 2));

  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addrHigh && !wrEn) ##1 (rdEn && !addrHigh && !wrEn)
      |-> rdData == $past(cntValue[BYTE_W-1:0]));

  assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);

  assert_low_read_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !addrHigh && !wrEn) ##1 (rdEn && !addrHigh && !wrEn) |-> $stable(rdData));
endmodule

bind counter_byte_access counter_byte_access_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .addrHigh(addrHigh), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .cntValue(cntValue),
  .loadValue(loadValue), .loadStrobe(loadStrobe)
);

// File: tb/counter_byte_access_tb.sv
module counter_byte_access_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrHigh = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [15:0] cntValue = '0;
  logic [15:0] loadValue;
  logic        loadStrobe;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0]  mBuf = '0;
  logic        mStrobe = 1'b0;
  logic [15:0] mLoad = '0;
  string       tagOverride = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  counter_byte_access u_dut (
    .clk(clk), .rstN(rstN), .addrHigh(addrHigh), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .cntValue(cntValue),
    .loadValue(loadValue), .loadStrobe(loadStrobe)
  );

  function automatic logic [7:0] expRead(logic a, logic rd, logic [7:0] buff, logic [15:0] cnt);
    if (!rd) return 8'h00;
    return a ? cnt[15:8] : buff;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic a, logic wr, logic rd, logic [7:0] wd, logic [15:0] cnt);
    string tagRd, tagLd;
    @(negedge clk);
    addrHigh = a; wrEn = wr; rdEn = rd; wrData = wd; cntValue = cnt;
    #(CLK_PERIOD/4);
    tagRd = !rd ? "R8" : (a ? "R5" : "R6");
    if (tagOverride != "") tagRd = tagOverride;
    check(tagRd, {24'd0, rdData}, {24'd0, expRead(a, rd, mBuf, cnt)});
    @(posedge clk);
    mStrobe = wr && a;
    if (wr && !a) mBuf = wd;
    else if (wr && a) mLoad = {wd, mBuf};
    else if (rd && a) mBuf = cnt[7:0];
    #1;
    tagLd = (wr && a) ? "R3" : (wr ? "R2" : "R4");
    if (tagOverride != "") tagLd = tagOverride;
    check(tagLd, {31'd0, loadStrobe}, {31'd0, mStrobe});
    check(tagLd, {16'd0, loadValue}, {16'd0, mLoad});
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", {31'd0, loadStrobe}, 32'd0);
    check("R1", {16'd0, loadValue}, 32'd0);
    @(negedge clk) rstN = 1'b1;
    tagOverride = "R1";
    step(1'b0, 1'b0, 1'b1, 8'h00, 16'hBEEF); // buffer still zero
    tagOverride = "";

    // R2/R3: ordered preload
    step(1'b0, 1'b1, 1'b0, 8'h34, 16'h0000);
    step(1'b1, 1'b1, 1'b0, 8'h12, 16'h0000); // load 0x1234
    step(1'b0, 1'b0, 1'b0, 8'h00, 16'h0000); // R4 drop

    // R6: snapshot read pair with live value changing
    step(1'b1, 1'b0, 1'b1, 8'h00, 16'hA55A);
    step(1'b0, 1'b0, 1'b1, 8'h00, 16'h00FF); // expects 5A
    // R10: repeated low reads
    tagOverride = "R10";
    step(1'b0, 1'b0, 1'b1, 8'h00, 16'h0011);
    step(1'b0, 1'b0, 1'b1, 8'h00, 16'h0022);
    tagOverride = "";

    // R7: high read overwrites staged low byte
    step(1'b0, 1'b1, 1'b0, 8'hC3, 16'h0000);
    tagOverride = "R7";
    step(1'b1, 1'b0, 1'b1, 8'h00, 16'h7E81);
    step(1'b1, 1'b1, 1'b0, 8'h99, 16'h0000); // load 0x9981
    tagOverride = "";

    // R9: write and read together on high byte
    step(1'b0, 1'b1, 1'b0, 8'h66, 16'h0000);
    tagOverride = "R9";
    step(1'b1, 1'b1, 1'b1, 8'h44, 16'hF00D);  // no snapshot, load 0x4466
    step(1'b1, 1'b1, 1'b0, 8'h55, 16'h0000);  // buffer still 66
    step(1'b0, 1'b1, 1'b1, 8'h77, 16'h1234);  // low write with read
    step(1'b0, 1'b0, 1'b1, 8'h00, 16'h0000);  // returns 77
    tagOverride = "";

    // back-to-back high writes (R4 stays high only per write)
    step(1'b1, 1'b1, 1'b0, 8'h01, 16'h0000);
    step(1'b1, 1'b1, 1'b0, 8'h02, 16'h0000);
    step(1'b0, 1'b0, 1'b0, 8'h00, 16'h0000);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] kind;
      kind = 3'($urandom_range(0, 5));
      step(1'($urandom), kind[0] | (kind == 3'd4), kind[1] | (kind == 3'd5),
           8'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule